// File: doc/BRIEF.md
# Prescaled Timer/Counter with Match and Capture Channels

The block is a free-running up-counter with a programmable prescaler, a set of match channels and a set of capture channels. In timer mode the counter advances once for every (limit + 1) cycles of the clock. In event mode the prescaler is bypassed and the counter advances on chosen edges of one selected capture input. Each match channel compares its register with the counter. On a hit it can flag an interrupt, restart the counter, stop it, and drive its own external output pin low, high, inverted or unchanged.

Capture channels resynchronise their pins through two flops and then detect edges. On a rising or falling edge, or both, they latch the counter value. Capture inputs that are not selected as the event source keep working as ordinary capture inputs. All state is reached through a simple synchronous register bus. Writes take effect at the clock edge that samples them. Read data is registered.

Register word addresses: 0 control (bit0 run, bit1 hold-in-zero), 1 mode, 2 counter, 3 prescale limit, 4 prescale count, 5 flags, 6 match config, 7 capture config, 8 pin control, 9..12 match values, 13..16 captured values.

Top module: `evtmr_timer`

## Requirements
- R1: After reset every register reads 0, and ext_out and irq are 0.
- R2: In timer mode (mode bits[1:0]=0) with the run bit set, the counter advances once every limit+1 clocks. After the edge that sets run, the counter holds floor(j/(limit+1)) following j further edges. While hold (control bit1) is set, the counter and the prescaler stay at 0.
- R3: In event mode the counter advances only on edges of the capture input picked by mode bits[3:2]. Mode bits[1:0] select the edges: 1 rising, 2 falling, 3 both. The prescale count stays 0, and edges on other inputs do not advance the counter.
- R4: The flags register holds match flags in bits[3:0] and capture flags in bits[7:4]. A flag is set when its event occurs and stays set until a 1 is written to its bit.
- R5: A match event occurs on the tick that brings the counter to the match value. If match config bit 3i+1 is set, the tick that follows a counter equal to match i loads 0, so the counter cycles through 0..M.
- R6: If match config bit 3i+2 is set, the run bit clears on the same edge that the counter reaches match i, and the counter stays at that value.
- R7: Pin control bits[3:0] are the output state. Bits[5+2i:4+2i] set the action for match i: 0 keep, 1 drive low, 2 drive high, 3 invert. The action is applied on each event of match i.
- R8: Capture config bits 3i and 3i+1 enable capture on rising and falling edges of cap_in[i]. An edge is latched at the third clock edge after the pin changes, using the counter value before that edge. Edges that are not enabled leave the captured value unchanged.
- R9: irq is the OR of the flags whose enable is set: match config bit 3i for match i, capture config bit 3i+2 for capture i.
- R10: In event mode, the capture inputs that are not the event source still capture normally.
- R11: bus_rdata shows the addressed register as it was just before the edge that sampled bus_rd. It keeps that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cap_in | input | 4 | Asynchronous capture / event inputs |
| ext_out | output | 4 | Match-driven output pins |
| irq | output | 1 | Interrupt request |

## Verification
Counter, flag, pin and run-bit results appear at the clock edge that carries the tick, so the bench counts edges from the write that sets run. It samples ext_out at the following falling edge. Register reads return the state from one edge earlier, and every expected count is taken at that edge rather than at the edge on which the read returns. Pin stimuli are followed by four idle cycles, which covers the three-edge synchroniser and capture path before any captured value or event count is read.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;

    typedef enum logic [1:0] {
        SRC_TIMER = 2'd0,
        SRC_RISE  = 2'd1,
        SRC_FALL  = 2'd2,
        SRC_BOTH  = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        ACT_KEEP = 2'd0,
        ACT_LOW  = 2'd1,
        ACT_HIGH = 2'd2,
        ACT_FLIP = 2'd3
    } outact_e;

    typedef struct packed {
        logic stop;
        logic zero;
        logic irq;
    } mcfg_t;

    typedef struct packed {
        logic irq;
        logic fall;
        logic rise;
    } ccfg_t;

    localparam int REG_CTRL   = 0;
    localparam int REG_MODE   = 1;
    localparam int REG_COUNT  = 2;
    localparam int REG_LIMIT  = 3;
    localparam int REG_PCOUNT = 4;
    localparam int REG_FLAGS  = 5;
    localparam int REG_MCFG   = 6;
    localparam int REG_CCFG   = 7;
    localparam int REG_EXT    = 8;
    localparam int REG_MR0    = 9;

    function automatic logic next_pin(input logic [1:0] act, input logic cur);
        case (outact_e'(act))
            ACT_LOW:  return 1'b0;
            ACT_HIGH: return 1'b1;
            ACT_FLIP: return ~cur;
            default:  return cur;
        endcase
    endfunction

    function automatic logic src_hit(input src_e s, input logic r, input logic f);
        return (r && (s == SRC_RISE || s == SRC_BOTH)) ||
               (f && (s == SRC_FALL || s == SRC_BOTH));
    endfunction

endpackage

// File: rtl/evtmr_edge.sv
module evtmr_edge #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pins,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] meta, stab, prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            stab <= '0;
            prev <= '0;
        end else begin
            meta <= pins;
            stab <= meta;
            prev <= stab;
        end
    end

    assign rise = stab & ~prev;
    assign fall = ~stab & prev;
endmodule

// File: rtl/evtmr_prescale.sv
module evtmr_prescale import evtmr_pkg::*; #(
    parameter int W  = 32,
    parameter int N  = 4,
    parameter int SW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          hold,
    input  src_e          src,
    input  logic [SW-1:0] sel,
    input  logic [N-1:0]  rise,
    input  logic [N-1:0]  fall,
    input  logic [W-1:0]  limit,
    output logic [W-1:0]  pcount,
    output logic          tick
);
    localparam logic [W-1:0] ONE = W'(1);
    logic at_lim;

    assign at_lim = (pcount >= limit);

    always_ff @(posedge clk) begin
        if (rst || hold)
            pcount <= '0;
        else if (run && src == SRC_TIMER)
            pcount <= at_lim ? '0 : pcount + ONE;
    end

    always_comb begin
        if (!run || hold)
            tick = 1'b0;
        else if (src == SRC_TIMER)
            tick = at_lim;
        else
            tick = src_hit(src, rise[sel], fall[sel]);
    end
endmodule

// File: rtl/evtmr_capture.sv
module evtmr_capture import evtmr_pkg::*; #(
    parameter int W = 32,
    parameter int N = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N-1:0]        rise,
    input  logic [N-1:0]        fall,
    input  ccfg_t [N-1:0]       cfg,
    input  logic [W-1:0]        count,
    output logic [N-1:0]        evt,
    output logic [N-1:0][W-1:0] cap
);
    for (genvar i = 0; i < N; i++) begin : g_ch
        assign evt[i] = (rise[i] & cfg[i].rise) | (fall[i] & cfg[i].fall);

        always_ff @(posedge clk) begin
            if (rst)
                cap[i] <= '0;
            else if (evt[i])
                cap[i] <= count;
        end

        assert_latch_R8: assert property (@(posedge clk) disable iff (rst)
            evt[i] |=> cap[i] == $past(count));
    end
endmodule

// File: rtl/evtmr_match.sv
module evtmr_match import evtmr_pkg::*; #(
    parameter int W = 32,
    parameter int N = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [W-1:0]        count,
    input  logic [W-1:0]        count_nxt,
    input  logic                adv,
    input  logic [N-1:0][W-1:0] mr,
    input  mcfg_t [N-1:0]       mcfg,
    input  logic [N-1:0][1:0]   acts,
    input  logic                ext_wr,
    input  logic [N-1:0]        ext_wdata,
    output logic [N-1:0]        evt,
    output logic                rst_hit,
    output logic [N-1:0]        ext_out
);
    logic [N-1:0] zhit;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign evt[i]  = adv && (count_nxt == mr[i]);
        assign zhit[i] = mcfg[i].zero && (count == mr[i]);

        assert_pin_flip_R7: assert property (@(posedge clk) disable iff (rst)
            (evt[i] && acts[i] == ACT_FLIP && !ext_wr) |=> ext_out[i] != $past(ext_out[i]));
    end

    assign rst_hit = |zhit;

    always_ff @(posedge clk) begin
        if (rst)
            ext_out <= '0;
        else if (ext_wr)
            ext_out <= ext_wdata;
        else
            for (int i = 0; i < N; i++)
                if (evt[i]) ext_out[i] <= next_pin(acts[i], ext_out[i]);
    end
endmodule

// File: rtl/evtmr_timer.sv
module evtmr_timer import evtmr_pkg::*; #(
    parameter int W   = 32,
    parameter int NCH = 4,
    parameter int AW  = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic [AW-1:0]  bus_addr,
    input  logic [W-1:0]   bus_wdata,
    output logic [W-1:0]   bus_rdata,
    input  logic [NCH-1:0] cap_in,
    output logic [NCH-1:0] ext_out,
    output logic           irq
);
    localparam int SW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [W-1:0] ONE = W'(1);

    logic                    run, hold;
    src_e                    src;
    logic [SW-1:0]           sel;
    logic [W-1:0]            count, count_nxt, limit, pcount, rd_mux;
    logic [2*NCH-1:0]        flags, irq_mask;
    mcfg_t [NCH-1:0]         mcfg;
    ccfg_t [NCH-1:0]         ccfg;
    logic [NCH-1:0][1:0]     acts;
    logic [NCH-1:0][W-1:0]   mr, cap;
    logic [NCH-1:0]          rise, fall, m_evt, c_evt, stop_req, w_mr;
    logic                    tick, rst_hit, adv;
    logic                    w_ctrl, w_mode, w_count, w_limit, w_flags, w_mcfg, w_ccfg, w_ext;

    assign w_ctrl  = bus_wr && bus_addr == AW'(REG_CTRL);
    assign w_mode  = bus_wr && bus_addr == AW'(REG_MODE);
    assign w_count = bus_wr && bus_addr == AW'(REG_COUNT);
    assign w_limit = bus_wr && bus_addr == AW'(REG_LIMIT);
    assign w_flags = bus_wr && bus_addr == AW'(REG_FLAGS);
    assign w_mcfg  = bus_wr && bus_addr == AW'(REG_MCFG);
    assign w_ccfg  = bus_wr && bus_addr == AW'(REG_CCFG);
    assign w_ext   = bus_wr && bus_addr == AW'(REG_EXT);

    for (genvar i = 0; i < NCH; i++) begin : g_mr
        assign w_mr[i]     = bus_wr && bus_addr == AW'(REG_MR0 + i);
        assign stop_req[i] = m_evt[i] & mcfg[i].stop;
    end

    evtmr_edge #(.N(NCH)) u_edge (
        .clk(clk), .rst(rst), .pins(cap_in), .rise(rise), .fall(fall));

    evtmr_prescale #(.W(W), .N(NCH), .SW(SW)) u_pre (
        .clk(clk), .rst(rst), .run(run), .hold(hold), .src(src), .sel(sel),
        .rise(rise), .fall(fall), .limit(limit), .pcount(pcount), .tick(tick));

    evtmr_capture #(.W(W), .N(NCH)) u_cap (
        .clk(clk), .rst(rst), .rise(rise), .fall(fall), .cfg(ccfg),
        .count(count), .evt(c_evt), .cap(cap));

    assign adv       = tick && !w_count;
    assign count_nxt = rst_hit ? '0 : count + ONE;

    evtmr_match #(.W(W), .N(NCH)) u_match (
        .clk(clk), .rst(rst), .count(count), .count_nxt(count_nxt), .adv(adv),
        .mr(mr), .mcfg(mcfg), .acts(acts), .ext_wr(w_ext),
        .ext_wdata(bus_wdata[NCH-1:0]), .evt(m_evt), .rst_hit(rst_hit), .ext_out(ext_out));

    always_ff @(posedge clk) begin
        if (rst || hold)
            count <= '0;
        else if (w_count)
            count <= bus_wdata;
        else if (tick)
            count <= count_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run   <= 1'b0;
            hold  <= 1'b0;
            src   <= SRC_TIMER;
            sel   <= '0;
            limit <= '0;
            mcfg  <= '0;
            ccfg  <= '0;
            acts  <= '0;
            mr    <= '0;
            flags <= '0;
        end else begin
            if (w_ctrl) begin
                run  <= bus_wdata[0];
                hold <= bus_wdata[1];
            end else if (|stop_req) begin
                run  <= 1'b0;
            end
            if (w_mode) begin
                src <= src_e'(bus_wdata[1:0]);
                sel <= bus_wdata[SW+1:2];
            end
            if (w_limit) limit <= bus_wdata;
            if (w_mcfg)  mcfg  <= bus_wdata[3*NCH-1:0];
            if (w_ccfg)  ccfg  <= bus_wdata[3*NCH-1:0];
            if (w_ext)   acts  <= bus_wdata[3*NCH-1:NCH];
            for (int i = 0; i < NCH; i++)
                if (w_mr[i]) mr[i] <= bus_wdata;
            flags <= (flags & ~(w_flags ? bus_wdata[2*NCH-1:0] : '0)) | {c_evt, m_evt};
        end
    end

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            irq_mask[i]       = mcfg[i].irq;
            irq_mask[NCH + i] = ccfg[i].irq;
        end
    end
    assign irq = |(flags & irq_mask);

    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            AW'(REG_CTRL):   rd_mux = W'({hold, run});
            AW'(REG_MODE):   rd_mux = W'({sel, src});
            AW'(REG_COUNT):  rd_mux = count;
            AW'(REG_LIMIT):  rd_mux = limit;
            AW'(REG_PCOUNT): rd_mux = pcount;
            AW'(REG_FLAGS):  rd_mux = W'(flags);
            AW'(REG_MCFG):   rd_mux = W'(mcfg);
            AW'(REG_CCFG):   rd_mux = W'(ccfg);
            AW'(REG_EXT):    rd_mux = W'({acts, ext_out});
            default:         rd_mux = '0;
        endcase
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == AW'(REG_MR0 + i))       rd_mux = mr[i];
            if (bus_addr == AW'(REG_MR0 + NCH + i)) rd_mux = cap[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_mux;
    end

    assert_timer_step_R2: assert property (@(posedge clk) disable iff (rst)
        (run && !hold && src == SRC_TIMER && limit == '0 && !rst_hit && !bus_wr)
        |=> count == $past(count) + ONE);

    assert_event_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (src != SRC_TIMER && !bus_wr && !src_hit(src, rise[sel], fall[sel]))
        |=> $stable(count));

    assert_flag_set_R4: assert property (@(posedge clk) disable iff (rst)
        (|m_evt) |=> ((flags[NCH-1:0] & $past(m_evt)) == $past(m_evt)));

    assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (tick && rst_hit && !bus_wr) |=> count == '0);

    assert_stop_run_R6: assert property (@(posedge clk) disable iff (rst)
        ((|stop_req) && !w_ctrl) |=> !run);
endmodule

// File: tb/evtmr_timer_test.sv
module evtmr_timer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  cap_in = '0;
    logic [3:0]  ext_out;
    logic        irq;

    int vectors = 0;
    int errors  = 0;

    localparam int A_CTRL = 0, A_MODE = 1, A_COUNT = 2, A_LIMIT = 3, A_PCOUNT = 4;
    localparam int A_FLAGS = 5, A_MCFG = 6, A_CCFG = 7, A_EXT = 8, A_MR0 = 9, A_CAP0 = 13;

    evtmr_timer uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
        .ext_out(ext_out), .irq(irq));

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = 5'(a);
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int ch, input int n);
        for (int k = 0; k < n; k++) begin
            cap_in[ch] = 1'b1; idle(2);
            cap_in[ch] = 1'b0; idle(2);
        end
        idle(4);
    endtask

    function automatic logic [31:0] pin_model(input int j);
        int flips;
        flips = (j >= 3) ? ((j - 3) / 10 + 1) : 0;
        return {28'd0, (j >= 6), flips[0], !(j >= 2), 1'b0};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [31:0] d, v, v2;
        int p, j, n, m;
        void'($urandom(32'd2024));
        idle(4);
        rst = 1'b0;

        // R1 reset state, R11 read latency
        rd(A_COUNT, d); check("R1 count", d, 0);
        rd(A_CTRL, d);  check("R1 ctrl", d, 0);
        rd(A_FLAGS, d); check("R1 flags", d, 0);
        rd(A_CAP0, d);  check("R1 cap0", d, 0);
        check("R1 ext_out", {28'd0, ext_out}, 0);
        check("R1 irq", {31'd0, irq}, 0);
        wr(A_LIMIT, 32'h1234_5678);
        rd(A_LIMIT, d); check("R11 readback", d, 32'h1234_5678);

        for (int i = 0; i < 4; i++) wr(A_MR0 + i, 32'hFFFF_FFFF);

        // R2 prescaled timer
        for (int t = 0; t < 8; t++) begin
            p = int'($urandom % 6);
            j = int'($urandom % 40);
            wr(A_CTRL, 2);
            wr(A_LIMIT, p);
            wr(A_CTRL, 1);
            idle(j);
            rd(A_COUNT, d);
            check("R2 prescale count", d, j / (p + 1));
        end
        wr(A_CTRL, 3);
        idle(5);
        rd(A_COUNT, d);  check("R2 hold count", d, 0);
        rd(A_PCOUNT, d); check("R2 hold prescaler", d, 0);

        // R5 reset on match, R4 sticky flag, R9 irq
        for (int t = 0; t < 3; t++) begin
            j = (t == 0) ? 17 : int'($urandom % 30);
            wr(A_CTRL, 2);
            wr(A_LIMIT, 0);
            wr(A_FLAGS, 32'hFF);
            wr(A_MR0, 5);
            wr(A_MCFG, (t == 2) ? 32'h2 : 32'h3);
            wr(A_CTRL, 1);
            idle(j);
            rd(A_COUNT, d);
            check("R5 wrap count", d, j % 6);
            check("R9 irq", {31'd0, irq}, (t != 2 && j + 1 >= 5) ? 1 : 0);
            rd(A_FLAGS, d);
            check("R4 match flag", d & 32'h1, (j + 1 >= 5) ? 1 : 0);
        end
        wr(A_CTRL, 0);
        wr(A_MCFG, 32'h3);
        wr(A_FLAGS, 32'h1);
        rd(A_FLAGS, d); check("R4 write one clears", d & 32'h1, 0);
        check("R9 irq cleared", {31'd0, irq}, 0);

        // R6 stop on match
        wr(A_CTRL, 2);
        wr(A_MCFG, 32'h20);
        wr(A_MR1_ADDR(), 7);
        wr(A_CTRL, 1);
        idle(20);
        rd(A_COUNT, d); check("R6 stopped count", d, 7);
        rd(A_CTRL, d);  check("R6 run cleared", d, 0);

        // R7 pin actions
        for (int t = 0; t < 3; t++) begin
            j = (t == 0) ? 23 : int'($urandom % 46);
            wr(A_CTRL, 2);
            wr(A_MR0, 9); wr(A_MR0 + 1, 2); wr(A_MR0 + 2, 3); wr(A_MR0 + 3, 6);
            wr(A_MCFG, 32'h2);
            wr(A_EXT, 32'hB42);
            wr(A_CTRL, 1);
            idle(j);
            check("R7 pins", {28'd0, ext_out}, pin_model(j));
        end

        // R8 capture edges with counter still
        wr(A_CTRL, 2);
        wr(A_CTRL, 0);
        wr(A_MCFG, 0);
        wr(A_FLAGS, 32'hFF);
        for (int t = 0; t < 3; t++) begin
            v = $urandom; v2 = $urandom;
            wr(A_CCFG, 32'h8);
            wr(A_COUNT, v);
            cap_in[1] = 1'b1; idle(4);
            rd(A_CAP0 + 1, d); check("R8 rising capture", d, v);
            wr(A_COUNT, v2);
            cap_in[1] = 1'b0; idle(4);
            rd(A_CAP0 + 1, d); check("R8 falling ignored", d, v);
            wr(A_CCFG, 32'h18);
            cap_in[1] = 1'b1; idle(4);
            rd(A_CAP0 + 1, d); check("R8 both edges rise", d, v2);
            wr(A_COUNT, v);
            cap_in[1] = 1'b0; idle(4);
            rd(A_CAP0 + 1, d); check("R8 both edges fall", d, v);
        end
        rd(A_FLAGS, d); check("R4 capture flag", d & 32'h20, 32'h20);
        wr(A_CCFG, 32'h400);
        cap_in[3] = 1'b1; idle(4);
        rd(A_CAP0 + 3, d); check("R8 rise ignored", d, 0);
        cap_in[3] = 1'b0; idle(4);
        rd(A_CAP0 + 3, d); check("R8 falling capture", d, v);

        // R3 event counting, R10 other inputs still capture
        wr(A_CTRL, 2);
        wr(A_MCFG, 0);
        wr(A_MODE, 32'h9);
        wr(A_CCFG, 32'h1);
        wr(A_CTRL, 1);
        n = int'($urandom % 5) + 3;
        pulse(2, n);
        rd(A_COUNT, d);  check("R3 rising events", d, n);
        rd(A_PCOUNT, d); check("R3 prescaler bypassed", d, 0);
        pulse(0, 1);
        rd(A_CAP0, d);   check("R10 side capture", d, n);
        rd(A_COUNT, d);  check("R3 other input no count", d, n);
        wr(A_MODE, 32'hB);
        m = int'($urandom % 4) + 2;
        pulse(2, m);
        rd(A_COUNT, d);  check("R3 both-edge events", d, n + 2 * m);
        wr(A_MODE, 32'hA);
        pulse(2, 3);
        rd(A_COUNT, d);  check("R3 falling events", d, n + 2 * m + 3);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    function automatic int A_MR1_ADDR();
        return A_MR0 + 1;
    endfunction
endmodule